// File: doc/BRIEF.md
# Exception Entry Vectoring Sequencer

This block moves a CPU core from normal execution into a handler when an exception or an interrupt is raised. Each cycle it looks at a pending exception code, a pending interrupt request with its event code and priority level, the core's sleep and delay-slot state, and the current PC, R15 and vector base. When an event is accepted, it does the whole entry update on one clock edge:

- it saves the status word, the PC and R15 into shadow registers;
- it raises the block, privileged-mode and register-bank bits of the status word;
- it records the event code;
- it computes the handler address.

The status word lives in this block. The core can also load it through a simple write strobe. The block gives out a one-cycle taken pulse with the new PC. It also pulses a request to clear the delay-slot flags and a wake pulse for a sleeping core.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are pending in the same cycle, only the exception is taken. The exception code goes to the exception event register, and the interrupt event register keeps its value.
- R2: While the block bit (status bit 28) is set, any exception whose code is not 0x1E0 is recorded and vectored as code 0x000, the reset class. Code 0x1E0 is taken unchanged.
- R3: While the block bit is set, an interrupt is ignored unless `sleeping` is high. When a sleeping core takes an interrupt, `wake` pulses with `taken`.
- R4: An interrupt is taken only when its level is strictly greater than the mask in status bits 7:4. Otherwise no output and no register changes.
- R5: On entry, the shadow status gets the old status word, the saved PC gets the PC and the saved R15 gets R15. Status bits 28 (block), 29 (bank) and 30 (privileged) are then set.
- R6: When `in_delay_slot` is high on entry, the saved PC is the PC minus 2, and `clear_delay` pulses with `taken`.
- R7: Codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set the mask field to 0xF and jump to 0xA0000000.
- R8: Codes 0x040 and 0x060 jump to the vector base plus 0x400.
- R9: An accepted interrupt writes its code to the interrupt event register and jumps to the vector base plus 0x600. The exception event register is unchanged.
- R10: Every other exception writes its code to the exception event register and jumps to the vector base plus 0x100.
- R11: For code 0x160 the saved PC is the PC plus 2. Combined with a delay slot, the saved PC equals the PC.
- R12: All register updates and the `taken`, `target_pc`, `clear_delay` and `wake` outputs appear one clock edge after the event is presented. `taken` falls on the next edge unless a new event is accepted.
- R13: With no event pending and no status write, every register keeps its value and `taken` stays low.
- R14: `sr_wr` loads `sr_wdata` into the status word when no event is taken. In a cycle where an event is taken, the entry value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | An interrupt is pending |
| irq_code | input | 12 | Event code of the pending interrupt |
| irq_level | input | 4 | Priority level of the pending interrupt |
| sleeping | input | 1 | Core is in sleep state |
| in_delay_slot | input | 1 | Current instruction is in a delay slot |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current general register 15 |
| vbr_in | input | 32 | Vector base |
| sr_wr | input | 1 | Status word write strobe |
| sr_wdata | input | 32 | Status word write data |
| taken | output | 1 | One-cycle entry pulse |
| target_pc | output | 32 | Handler address, valid with `taken` |
| clear_delay | output | 1 | Clear delay-slot flags, with `taken` |
| wake | output | 1 | Leave sleep, with `taken` |
| sr_q | output | 32 | Status word |
| ssr_q | output | 32 | Saved status word |
| spc_q | output | 32 | Saved PC |
| sgr_q | output | 32 | Saved R15 |
| expevt_q | output | 12 | Exception event code |
| intevt_q | output | 12 | Interrupt event code |

## Verification
A wrong code substitution or a wrong priority decision shows one edge after the stimulus. It appears at once as a wrong `target_pc` or a wrong event register value. A wrong status update is visible at once on `sr_q`. It also shows on the following event, because the shadow status then captures the bad value, and because a stale block bit or mask changes whether the next event is taken at all. The tests therefore check each entry in the cycle after it. They also present events after status changes, so that state carried between entries is exercised.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0] SR_INIT  = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              sleeping,
  input  logic              in_delay_slot,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              sr_wr,
  input  logic [XLEN-1:0]   sr_wdata,
  output logic              taken,
  output logic [XLEN-1:0]   target_pc,
  output logic              clear_delay,
  output logic              wake,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   sgr_q,
  output logic [CODE_W-1:0] expevt_q,
  output logic [CODE_W-1:0] intevt_q
);
  localparam int BL_BIT = 28;
  localparam int RB_BIT = 29;
  localparam int MD_BIT = 30;
  localparam int FD_BIT = 15;
  localparam int IM_LO  = 4;
  localparam int IM_HI  = IM_LO + LVL_W - 1;

  localparam logic [CODE_W-1:0] C_RESET  = CODE_W'(12'h000);
  localparam logic [CODE_W-1:0] C_RESET2 = CODE_W'(12'h020);
  localparam logic [CODE_W-1:0] C_MULTI  = CODE_W'(12'h140);
  localparam logic [CODE_W-1:0] C_MISS_R = CODE_W'(12'h040);
  localparam logic [CODE_W-1:0] C_MISS_W = CODE_W'(12'h060);
  localparam logic [CODE_W-1:0] C_TRAP   = CODE_W'(12'h160);
  localparam logic [CODE_W-1:0] C_BYPASS = CODE_W'(12'h1E0);

  localparam logic [XLEN-1:0] OFF_GEN  = XLEN'(32'h100);
  localparam logic [XLEN-1:0] OFF_MISS = XLEN'(32'h400);
  localparam logic [XLEN-1:0] OFF_IRQ  = XLEN'(32'h600);
  localparam logic [XLEN-1:0] STEP     = XLEN'(2);

  logic              blocked;
  logic [CODE_W-1:0] code_eff;
  logic              irq_ok, take;
  logic              is_rst, is_miss, is_trap;
  logic [XLEN-1:0]   spc_calc, sr_entry, pc_calc;

  assign blocked  = sr_q[BL_BIT];
  assign code_eff = (blocked && exc_code != C_BYPASS) ? C_RESET : exc_code;
  assign irq_ok   = irq_req && !exc_valid && (!blocked || sleeping)
                    && (irq_level > sr_q[IM_HI:IM_LO]);
  assign take     = exc_valid || irq_ok;

  assign is_rst  = (code_eff == C_RESET) || (code_eff == C_RESET2) || (code_eff == C_MULTI);
  assign is_miss = (code_eff == C_MISS_R) || (code_eff == C_MISS_W);
  assign is_trap = exc_valid && (code_eff == C_TRAP);

  assign spc_calc = pc_in - (in_delay_slot ? STEP : '0) + (is_trap ? STEP : '0);

  always_comb begin
    sr_entry = sr_q;
    sr_entry[BL_BIT] = 1'b1;
    sr_entry[RB_BIT] = 1'b1;
    sr_entry[MD_BIT] = 1'b1;
    if (exc_valid && is_rst) begin
      sr_entry[FD_BIT] = 1'b0;
      sr_entry[IM_HI:IM_LO] = '1;
    end
  end

  always_comb begin
    if (!exc_valid)   pc_calc = vbr_in + OFF_IRQ;
    else if (is_rst)  pc_calc = RESET_PC;
    else if (is_miss) pc_calc = vbr_in + OFF_MISS;
    else              pc_calc = vbr_in + OFF_GEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q        <= SR_INIT;
      ssr_q       <= '0;
      spc_q       <= '0;
      sgr_q       <= '0;
      expevt_q    <= '0;
      intevt_q    <= '0;
      taken       <= 1'b0;
      target_pc   <= '0;
      clear_delay <= 1'b0;
      wake        <= 1'b0;
    end else begin
      taken       <= take;
      clear_delay <= take && in_delay_slot;
      wake        <= take && sleeping;
      if (take) begin
        target_pc <= pc_calc;
        ssr_q     <= sr_q;
        spc_q     <= spc_calc;
        sgr_q     <= r15_in;
        sr_q      <= sr_entry;
        if (exc_valid) expevt_q <= code_eff;
        else           intevt_q <= irq_code;
      end else if (sr_wr) begin
        sr_q <= sr_wdata;
      end
    end
  end

  a_r1_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && irq_req) |=> ($stable(intevt_q) && taken));

  a_r4_level_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !exc_valid && irq_level <= sr_q[IM_HI:IM_LO]) |=> !taken);

  a_r5_context: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ssr_q == $past(sr_q) && sgr_q == $past(r15_in)
              && sr_q[BL_BIT] && sr_q[RB_BIT] && sr_q[MD_BIT]));

  a_r7_reset_class: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && target_pc == RESET_PC) |-> (sr_q[IM_HI:IM_LO] == '1 && !sr_q[FD_BIT]));

  a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !irq_req && !sr_wr) |=> (!taken && $stable(sr_q) && $stable(spc_q)
                                            && $stable(expevt_q) && $stable(intevt_q)));

  a_r6_delay_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clear_delay |-> taken);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_valid = 0, irq_req = 0, sleeping = 0, in_delay_slot = 0, sr_wr = 0;
  logic [11:0] exc_code = 0, irq_code = 0;
  logic [3:0]  irq_level = 0;
  logic [31:0] pc_in = 0, r15_in = 0, vbr_in = 32'h8C00_0000, sr_wdata = 0;
  logic        taken, clear_delay, wake;
  logic [31:0] target_pc, sr_q, ssr_q, spc_q, sgr_q;
  logic [11:0] expevt_q, intevt_q;

  int n_chk = 0, n_bad = 0;
  localparam logic [31:0] VB = 32'h8C00_0000;
  localparam logic [31:0] USR = 32'h0000_8030;

  always #10 clk = ~clk;

  exc_entry_seq uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_sr(logic [31:0] v);
    @(negedge clk); sr_wr = 1; sr_wdata = v;
    @(negedge clk); sr_wr = 0;
  endtask

  task automatic apply(logic ev, logic [11:0] ec, logic iv, logic [11:0] ic, logic [3:0] lv,
                       logic slp, logic ds, logic [31:0] pc, logic [31:0] r15);
    @(negedge clk);
    exc_valid = ev; exc_code = ec; irq_req = iv; irq_code = ic; irq_level = lv;
    sleeping = slp; in_delay_slot = ds; pc_in = pc; r15_in = r15;
    @(negedge clk);
    exc_valid = 0; irq_req = 0; sleeping = 0; in_delay_slot = 0;
  endtask

  task automatic t_reset;
    chk("R12 reset taken", {31'b0, taken}, 0);
    chk("R5 reset sr", sr_q, 32'h7000_00F0);
    chk("R10 reset expevt", {20'b0, expevt_q}, 0);
  endtask

  task automatic t_general;
    write_sr(USR);
    chk("R14 sr write", sr_q, USR);
    apply(1, 12'h180, 0, 0, 0, 0, 0, 32'h1000, 32'h55);
    chk("R12 taken", {31'b0, taken}, 1);
    chk("R10 target", target_pc, VB + 32'h100);
    chk("R10 expevt", {20'b0, expevt_q}, 32'h180);
    chk("R5 ssr", ssr_q, USR);
    chk("R5 spc", spc_q, 32'h1000);
    chk("R5 sgr", sgr_q, 32'h55);
    chk("R5 sr bits", sr_q, 32'h7000_8030);
    chk("R6 no clear", {31'b0, clear_delay}, 0);
    @(negedge clk);
    chk("R12 pulse ends", {31'b0, taken}, 0);
  endtask

  task automatic t_miss;
    write_sr(USR);
    apply(1, 12'h040, 0, 0, 0, 0, 0, 32'h1100, 0);
    chk("R8 miss read", target_pc, VB + 32'h400);
    write_sr(USR);
    apply(1, 12'h060, 0, 0, 0, 0, 0, 32'h1100, 0);
    chk("R8 miss write", target_pc, VB + 32'h400);
    chk("R8 expevt", {20'b0, expevt_q}, 32'h060);
  endtask

  task automatic t_reset_class;
    write_sr(USR);
    apply(1, 12'h020, 0, 0, 0, 0, 0, 32'h1200, 0);
    chk("R7 target", target_pc, 32'hA000_0000);
    chk("R7 sr", sr_q, 32'h7000_00F0);
    write_sr(USR);
    apply(1, 12'h140, 0, 0, 0, 0, 0, 32'h1200, 0);
    chk("R7 multi target", target_pc, 32'hA000_0000);
  endtask

  task automatic t_trap_delay;
    write_sr(USR);
    apply(1, 12'h160, 0, 0, 0, 0, 0, 32'h2000, 0);
    chk("R11 spc", spc_q, 32'h2002);
    chk("R11 target", target_pc, VB + 32'h100);
    write_sr(USR);
    apply(1, 12'h180, 0, 0, 0, 0, 1, 32'h3000, 0);
    chk("R6 spc", spc_q, 32'h2FFE);
    chk("R6 clear_delay", {31'b0, clear_delay}, 1);
    write_sr(USR);
    apply(1, 12'h160, 0, 0, 0, 0, 1, 32'h3000, 0);
    chk("R11 trap in slot", spc_q, 32'h3000);
  endtask

  task automatic t_irq;
    logic [11:0] ev0;
    write_sr(USR);
    ev0 = expevt_q;
    apply(0, 0, 1, 12'h3C0, 4'd5, 0, 0, 32'h4000, 0);
    chk("R9 taken", {31'b0, taken}, 1);
    chk("R9 intevt", {20'b0, intevt_q}, 32'h3C0);
    chk("R9 target", target_pc, VB + 32'h600);
    chk("R9 expevt kept", {20'b0, expevt_q}, {20'b0, ev0});
    write_sr(USR);
    apply(0, 0, 1, 12'h400, 4'd3, 0, 0, 32'h4100, 0);
    chk("R4 equal level", {31'b0, taken}, 0);
    chk("R4 sr kept", sr_q, USR);
    chk("R4 intevt kept", {20'b0, intevt_q}, 32'h3C0);
    apply(0, 0, 1, 12'h420, 4'd4, 0, 0, 32'h4100, 0);
    chk("R4 higher level", {20'b0, intevt_q}, 32'h420);
  endtask

  task automatic t_priority;
    write_sr(USR);
    apply(1, 12'h0A0, 1, 12'h500, 4'd9, 0, 0, 32'h5000, 0);
    chk("R1 expevt", {20'b0, expevt_q}, 32'h0A0);
    chk("R1 intevt kept", {20'b0, intevt_q}, 32'h420);
    chk("R1 target", target_pc, VB + 32'h100);
  endtask

  task automatic t_blocked;
    write_sr(32'h1000_8030);
    apply(1, 12'h180, 0, 0, 0, 0, 0, 32'h6000, 0);
    chk("R2 expevt reset", {20'b0, expevt_q}, 0);
    chk("R2 target", target_pc, 32'hA000_0000);
    chk("R2 sr", sr_q, 32'h7000_00F0);
    write_sr(32'h1000_8030);
    apply(1, 12'h1E0, 0, 0, 0, 0, 0, 32'h6000, 0);
    chk("R2 bypass code", {20'b0, expevt_q}, 32'h1E0);
    chk("R2 bypass target", target_pc, VB + 32'h100);
    write_sr(32'h1000_8030);
    apply(1, 12'h160, 0, 0, 0, 0, 0, 32'h6000, 0);
    chk("R2 trap becomes reset spc", spc_q, 32'h6000);
    write_sr(32'h1000_8030);
    apply(0, 0, 1, 12'h600, 4'd9, 0, 0, 32'h6100, 0);
    chk("R3 blocked irq", {31'b0, taken}, 0);
    chk("R3 intevt kept", {20'b0, intevt_q}, 32'h420);
    apply(0, 0, 1, 12'h600, 4'd9, 1, 0, 32'h6100, 0);
    chk("R3 sleeping irq", {20'b0, intevt_q}, 32'h600);
    chk("R3 wake", {31'b0, wake}, 1);
  endtask

  task automatic t_idle_and_race;
    logic [31:0] s0, p0;
    write_sr(USR);
    s0 = sr_q; p0 = spc_q;
    repeat (3) @(negedge clk);
    chk("R13 taken", {31'b0, taken}, 0);
    chk("R13 sr", sr_q, s0);
    chk("R13 spc", spc_q, p0);
    @(negedge clk);
    exc_valid = 1; exc_code = 12'h180; sr_wr = 1; sr_wdata = 32'h0000_0000; pc_in = 32'h7000;
    @(negedge clk);
    exc_valid = 0; sr_wr = 0;
    chk("R14 entry wins", sr_q, 32'h7000_8030);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_general();
    t_miss();
    t_reset_class();
    t_trap_delay();
    t_irq();
    t_priority();
    t_blocked();
    t_idle_and_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule